// File: doc/BRIEF.md
# Manchester Frame Serial Transmitter

This block accepts one frame worth of fields through a parallel load port guarded by a valid/ready handshake. The fields are a short header, a data word and a check word. It then sends the frame on one serial line in Manchester code. The frame opens with a long synchronisation symbol. The three user fields follow, and then a parity word that the block builds itself. Each of its bits makes the count of ones odd across the matching bits of the data and check words. While the frame is on the line the busy flag is high and the load port refuses new work. A producer that keeps its request raised is simply held until the line is free.

Timing is given in clock cycles. `HALF_CYC` is the length of one half of a data bit, and `START_MULT` scales it for each half of the opening symbol. At 100 MHz with `HALF_CYC = 5` and `START_MULT = 3`, a data half is 50 ns and each opening half is 150 ns. The line rests low whenever no frame is being sent.

Top module: `mfrm_tx`

## Requirements
- R1: Out of reset, and whenever no frame is in flight, `ld_ready_o` is 1, `busy_o` is 0 and `line_o` is 0.
- R2: A frame is taken at a rising clock edge where `ld_valid_i` and `ld_ready_o` are both 1. From the next cycle until the frame ends, `busy_o` is 1 and `ld_ready_o` is 0.
- R3: In the cycle after acceptance the line goes high for `START_MULT*HALF_CYC` cycles. It is then low for another `START_MULT*HALF_CYC` cycles.
- R4: Each following bit lasts `2*HALF_CYC` cycles, made of two halves of `HALF_CYC` cycles that each hold a steady level. A 1 is sent high then low, and a 0 is sent low then high.
- R5: After the opening symbol the bits go out as the header (`HDR_W` bits), then the data word, then the check word, then the parity word. Each field is sent most significant bit first.
- R6: Parity bit i is 1 exactly when data bit i and check bit i together hold an even number of ones, so those three bits hold an odd count. The header does not enter the parity.
- R7: `busy_o` falls, `ld_ready_o` rises and `line_o` is low exactly `2*START_MULT*HALF_CYC + 2*HALF_CYC*(HDR_W+3*WORD_W)` cycles after the accepting edge (1040 cycles with the defaults).
- R8: While a frame is in flight, changes on `ld_valid_i`, `hdr_i`, `data_i` and `chk_i` do not alter the frame being sent. A request held high during that time is taken at the first edge after `ld_ready_o` returns, and it is not lost.
- R9: With `ld_valid_i` held high, frames go out back to back. The next opening symbol starts two cycles after the previous frame ends, with exactly one low idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ld_valid_i | input | 1 | Load request |
| ld_ready_o | output | 1 | Load port free; a frame is taken when this and the request are both high |
| hdr_i | input | HDR_W | Header field |
| data_i | input | WORD_W | Data field |
| chk_i | input | WORD_W | Check field |
| line_o | output | 1 | Manchester serial output, low when idle |
| busy_o | output | 1 | High while a frame is on the line |

## Verification
Every result is due at a fixed cycle offset from the accepting edge. The line is high in cycles 0 to 14 after that edge and low in cycles 15 to 29. Bit b then owns cycles 30+10b to 39+10b, and the idle state returns at cycle 1040. The bench acts as a receiver. It samples the line on each falling edge from cycle 0 up to cycle 1039, and it checks the idle state at the falling edge of cycle 1040. From that record it checks the level of every cycle of every half-bit, rebuilds the fields and compares them with values computed by bench functions. The held-request and back-to-back cases begin the next capture at the falling edge right after the acceptance edge, so any drift of even one cycle shows up as a decode mismatch.

// File: rtl/mfrm_pkg.sv
package mfrm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SYNC_H = 3'd1,
    ST_SYNC_L = 3'd2,
    ST_HALF_A = 3'd3,
    ST_HALF_B = 3'd4
  } tx_state_e;

endpackage

// File: rtl/mfrm_rst_sync.sv
module mfrm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_o = sync_q;

endmodule

// File: rtl/mfrm_parity.sv
module mfrm_parity #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] data_i,
  input  logic [WORD_W-1:0] chk_i,
  output logic [WORD_W-1:0] par_o
);

  // odd count over {data, check, parity} per bit column
  for (genvar g = 0; g < WORD_W; g++) begin : g_col
    assign par_o[g] = ~(data_i[g] ^ chk_i[g]);
  end

endmodule

// File: rtl/mfrm_halftimer.sv
module mfrm_halftimer #(
  parameter int HALF_CYC   = 5,
  parameter int START_MULT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic load_i,
  input  logic long_i,
  output logic expire_o
);

  localparam int LONG_CYC = HALF_CYC * START_MULT;
  localparam int CW       = $clog2(LONG_CYC + 1);
  localparam logic [CW-1:0] LONG_RLD  = CW'(LONG_CYC - 1);
  localparam logic [CW-1:0] SHORT_RLD = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_en = 1'b1;
      cnt_d  = long_i ? LONG_RLD : SHORT_RLD;
    end else if (en_i && (cnt_q != '0)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expire_o = (cnt_q == '0);

endmodule

// File: rtl/mfrm_shifter.sv
module mfrm_shifter #(
  parameter int FRAME_W = 101
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic               shift_i,
  input  logic [FRAME_W-1:0] din_i,
  output logic               msb_o,
  output logic               nxt_o,
  output logic               last_o
);

  localparam int LW = $clog2(FRAME_W);
  localparam logic [LW-1:0] LEFT_RLD = LW'(FRAME_W - 1);

  logic [FRAME_W-1:0] sh_q;
  logic [FRAME_W-1:0] sh_d;
  logic [LW-1:0]      left_q;
  logic [LW-1:0]      left_d;
  logic               sh_en;

  always_comb begin
    sh_en  = load_i | shift_i;
    sh_d   = sh_q;
    left_d = left_q;
    if (load_i) begin
      sh_d   = din_i;
      left_d = LEFT_RLD;
    end else if (shift_i) begin
      sh_d   = {sh_q[FRAME_W-2:0], 1'b0};
      left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (sh_en) begin
      sh_q   <= sh_d;
      left_q <= left_d;
    end
  end

  assign msb_o  = sh_q[FRAME_W-1];
  assign nxt_o  = sh_q[FRAME_W-2];
  assign last_o = (left_q == '0);

endmodule

// File: rtl/mfrm_tx.sv
module mfrm_tx #(
  parameter int HDR_W      = 5,
  parameter int WORD_W     = 32,
  parameter int HALF_CYC   = 5,
  parameter int START_MULT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid_i,
  output logic              ld_ready_o,
  input  logic [HDR_W-1:0]  hdr_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic [WORD_W-1:0] chk_i,
  output logic              line_o,
  output logic              busy_o
);

  import mfrm_pkg::*;

  localparam int FRAME_W = HDR_W + 3 * WORD_W;

  logic               rst_sn;
  tx_state_e          st_q;
  tx_state_e          st_d;
  logic               line_q;
  logic               line_d;
  logic               accept;
  logic               busy;
  logic               expire;
  logic               tmr_load;
  logic               tmr_long;
  logic               sh_shift;
  logic               sh_msb;
  logic               sh_nxt;
  logic               sh_last;
  logic [WORD_W-1:0]  par_w;
  logic [FRAME_W-1:0] frame_w;

  mfrm_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_sn)
  );

  mfrm_parity #(.WORD_W(WORD_W)) u_par (
    .data_i (data_i),
    .chk_i  (chk_i),
    .par_o  (par_w)
  );

  assign frame_w = {hdr_i, data_i, chk_i, par_w};

  mfrm_halftimer #(.HALF_CYC(HALF_CYC), .START_MULT(START_MULT)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_sn),
    .en_i     (busy),
    .load_i   (tmr_load),
    .long_i   (tmr_long),
    .expire_o (expire)
  );

  mfrm_shifter #(.FRAME_W(FRAME_W)) u_sh (
    .clk     (clk),
    .rst_n   (rst_sn),
    .load_i  (accept),
    .shift_i (sh_shift),
    .din_i   (frame_w),
    .msb_o   (sh_msb),
    .nxt_o   (sh_nxt),
    .last_o  (sh_last)
  );

  assign busy     = (st_q != ST_IDLE);
  assign accept   = ld_valid_i & ~busy;
  assign tmr_load = accept | (busy & expire);
  assign tmr_long = accept | (st_q == ST_SYNC_H);
  assign sh_shift = (st_q == ST_HALF_B) & expire & ~sh_last;

  always_comb begin
    st_d   = st_q;
    line_d = line_q;
    unique case (st_q)
      ST_IDLE: begin
        line_d = 1'b0;
        if (ld_valid_i) begin
          st_d   = ST_SYNC_H;
          line_d = 1'b1;
        end
      end
      ST_SYNC_H: begin
        if (expire) begin
          st_d   = ST_SYNC_L;
          line_d = 1'b0;
        end
      end
      ST_SYNC_L: begin
        if (expire) begin
          st_d   = ST_HALF_A;
          line_d = sh_msb;
        end
      end
      ST_HALF_A: begin
        if (expire) begin
          st_d   = ST_HALF_B;
          line_d = ~sh_msb;
        end
      end
      ST_HALF_B: begin
        if (expire) begin
          if (sh_last) begin
            st_d   = ST_IDLE;
            line_d = 1'b0;
          end else begin
            st_d   = ST_HALF_A;
            line_d = sh_nxt;
          end
        end
      end
      default: begin
        st_d   = ST_IDLE;
        line_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q   <= ST_IDLE;
      line_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      line_q <= line_d;
    end
  end

  assign ld_ready_o = ~busy;
  assign busy_o     = busy;
  assign line_o     = line_q;

endmodule

// File: rtl/mfrm_tx_chk.sv
module mfrm_tx_chk #(
  parameter int HDR_W      = 5,
  parameter int WORD_W     = 32,
  parameter int HALF_CYC   = 5,
  parameter int START_MULT = 3
) (
  input logic clk,
  input logic rst_n,
  input logic ld_valid_i,
  input logic ld_ready_o,
  input logic line_o,
  input logic busy_o
);

  localparam int TOTAL = 2 * START_MULT * HALF_CYC + 2 * HALF_CYC * (HDR_W + 3 * WORD_W);
  localparam int RW    = $clog2(TOTAL + 2);

  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (busy_o) begin
      run_q <= run_q + 1'b1;
    end else begin
      run_q <= '0;
    end
  end

  a_r1_idle_line_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!line_o && ld_ready_o));

  a_r2_accept_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid_i && ld_ready_o) |=> (busy_o && !ld_ready_o));

  a_r3_opens_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> line_o);

  a_r8_refuse_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !ld_ready_o);

  a_r7_frame_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (run_q == RW'(TOTAL)));

endmodule

bind mfrm_tx mfrm_tx_chk #(
  .HDR_W(HDR_W), .WORD_W(WORD_W), .HALF_CYC(HALF_CYC), .START_MULT(START_MULT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ld_valid_i (ld_valid_i),
  .ld_ready_o (ld_ready_o),
  .line_o     (line_o),
  .busy_o     (busy_o)
);

// File: tb/mfrm_tx_tb.sv
module mfrm_tx_tb_top;

  localparam int HW    = 5;
  localparam int WW    = 32;
  localparam int HALF  = 5;
  localparam int MULT  = 3;
  localparam int NB    = HW + 3 * WW;
  localparam int SL    = MULT * HALF;
  localparam int TOTAL = 2 * SL + 2 * HALF * NB;

  logic          clk;
  logic          rst_n;
  logic          ld_valid_i;
  logic          ld_ready_o;
  logic [HW-1:0] hdr_i;
  logic [WW-1:0] data_i;
  logic [WW-1:0] chk_i;
  logic          line_o;
  logic          busy_o;

  int n_chk;
  int n_bad;
  bit done;

  mfrm_tx #(.HDR_W(HW), .WORD_W(WW), .HALF_CYC(HALF), .START_MULT(MULT)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_valid_i (ld_valid_i),
    .ld_ready_o (ld_ready_o),
    .hdr_i      (hdr_i),
    .data_i     (data_i),
    .chk_i      (chk_i),
    .line_o     (line_o),
    .busy_o     (busy_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [WW-1:0] exp_par(logic [WW-1:0] d, logic [WW-1:0] c);
    logic [WW-1:0] p;
    for (int i = 0; i < WW; i++) p[i] = ((d[i] + c[i]) % 2 == 0);
    return p;
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  // present a frame at a falling edge; returns at the falling edge of cycle 0
  task automatic launch(logic [HW-1:0] h, logic [WW-1:0] d, logic [WW-1:0] c);
    hdr_i      = h;
    data_i     = d;
    chk_i      = c;
    ld_valid_i = 1'b1;
    while (!ld_ready_o) @(negedge clk);
    @(negedge clk);
  endtask

  // receiver model: capture cycles 0..TOTAL-1, then check the idle cycle
  task automatic rx_check(logic [HW-1:0] h, logic [WW-1:0] d, logic [WW-1:0] c);
    logic [TOTAL-1:0] w;
    logic [NB-1:0]    rx;
    logic [WW-1:0]    p;
    int hs_err;
    int st_err;
    int enc_err;
    hs_err = 0;
    st_err = 0;
    enc_err = 0;
    for (int cyc = 0; cyc < TOTAL; cyc++) begin
      w[cyc] = line_o;
      if (!busy_o || ld_ready_o) hs_err++;
      @(negedge clk);
    end
    check(!busy_o && ld_ready_o && !line_o, "R7", "idle at frame end {busy,ready,line}",
          {61'd0, busy_o, ld_ready_o, line_o}, 64'b010);
    check(hs_err == 0, "R2", "busy/ready during frame bad cycles", hs_err, 0);
    for (int i = 0; i < 2 * SL; i++) if (w[i] != (i < SL)) st_err++;
    check(st_err == 0, "R3", "opening symbol bad cycles", st_err, 0);
    for (int b = 0; b < NB; b++) begin
      int base;
      base = 2 * SL + 2 * HALF * b;
      for (int k = 0; k < HALF; k++) begin
        if (w[base + k] != w[base]) enc_err++;
        if (w[base + HALF + k] == w[base]) enc_err++;
      end
      rx[NB - 1 - b] = w[base];
    end
    check(enc_err == 0, "R4", "Manchester half-bit bad cycles", enc_err, 0);
    p = exp_par(d, c);
    check(rx[NB-1 -: HW] == h, "R5", "header", rx[NB-1 -: HW], h);
    check(rx[3*WW-1 -: WW] == d, "R5", "data", rx[3*WW-1 -: WW], d);
    check(rx[2*WW-1 -: WW] == c, "R5", "check word", rx[2*WW-1 -: WW], c);
    check(rx[WW-1:0] == p, "R6", "parity word", rx[WW-1:0], p);
  endtask

  task automatic one_frame(logic [HW-1:0] h, logic [WW-1:0] d, logic [WW-1:0] c);
    launch(h, d, c);
    ld_valid_i = 1'b0;
    rx_check(h, d, c);
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    done  = 1'b0;
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [HW-1:0] h;
    logic [WW-1:0] d;
    logic [WW-1:0] c;
    void'($urandom(32'd20240517));
    rst_n      = 1'b0;
    ld_valid_i = 1'b0;
    hdr_i      = '0;
    data_i     = '0;
    chk_i      = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(ld_ready_o && !busy_o && !line_o, "R1", "reset {ready,busy,line}",
          {61'd0, ld_ready_o, busy_o, line_o}, 64'b100);
    // R1: idle line stays low with no request
    begin
      int hi;
      hi = 0;
      for (int i = 0; i < 20; i++) begin
        if (line_o || busy_o) hi++;
        @(negedge clk);
      end
      check(hi == 0, "R1", "idle activity cycles", hi, 0);
    end

    // directed corners (R4, R5, R6)
    one_frame('0, '0, '0);
    one_frame('1, '1, '0);
    one_frame('1, '1, '1);
    one_frame(5'b10101, 32'hAAAA_5555, 32'h0000_0000);
    one_frame(5'b00001, 32'h8000_0001, 32'hFFFF_0000);

    // random frames, check word mostly zero
    for (int n = 0; n < 8; n++) begin
      h = HW'($urandom());
      d = $urandom();
      c = (n % 3 == 2) ? $urandom() : '0;
      repeat ($urandom_range(0, 7)) @(negedge clk);
      one_frame(h, d, c);
    end

    // R8: inputs change while busy and the request stays high
    h = 5'b11001;
    d = 32'hDEAD_BEEF;
    c = 32'h0;
    launch(h, d, c);
    hdr_i  = 5'b00110;
    data_i = 32'h1234_5678;
    chk_i  = 32'hFFFF_FFFF;
    rx_check(h, d, c);
    // R9: held request taken right after the idle cycle, new content intact
    launch(5'b00110, 32'h1234_5678, 32'hFFFF_FFFF);
    check(busy_o && line_o, "R9", "back-to-back start {busy,line}",
          {62'd0, busy_o, line_o}, 64'b11);
    hdr_i  = 5'b01111;
    data_i = 32'h0F0F_F0F0;
    chk_i  = 32'h0;
    rx_check(5'b00110, 32'h1234_5678, 32'hFFFF_FFFF);
    launch(5'b01111, 32'h0F0F_F0F0, 32'h0);
    ld_valid_i = 1'b0;
    rx_check(5'b01111, 32'h0F0F_F0F0, 32'h0);

    repeat (5) @(negedge clk);
    check(ld_ready_o && !busy_o && !line_o, "R1", "final idle {ready,busy,line}",
          {61'd0, ld_ready_o, busy_o, line_o}, 64'b100);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule